// File: doc/BRIEF.md
# Signed Add/Subtract Unit with Overflow Detection

This block is a purely combinational two's-complement arithmetic stage. It takes two `W`-bit signed operands and two independent mode lines, one requesting addition and one requesting subtraction. It returns the first operand unchanged, the sum, or the difference, together with a carry-out and a signed overflow flag. One ripple adder does all the work.

The second operand is the only thing that changes between modes. It is gated to zero, passed straight, or inverted before it reaches the adder, and the adder's carry-in is tied to the subtract line. Subtraction is therefore the first operand plus the two's complement of the second. Any carry beyond the top bit is dropped from the result but is kept on its own output for unsigned use.

Overflow is taken from the disagreement between the carry entering the sign position and the carry leaving it. Raising both mode lines at once is illegal. The unit still produces a defined answer in that case, the difference, and it flags the condition on a separate error output. There are no registers: every output settles from the current inputs alone.

Top module: `addsub_unit`

## Requirements
- R1: With the add line high and the subtract line low, `sum_o` equals (`opa_i` + `opb_i`) modulo 2^W.
- R2: With the subtract line high and the add line low, `sum_o` equals (`opa_i` − `opb_i`) modulo 2^W.
- R3: With both mode lines low, `sum_o` equals `opa_i`, and `carry_o` and `ovf_o` are 0.
- R4: `carry_o` is bit W of the unsigned sum `opa_i` + B' + cin. B' is `opb_i` for add, ~`opb_i` for subtract and 0 for pass-through; cin is 1 only when subtracting. When subtracting, `carry_o` is 1 exactly when `opa_i` ≥ `opb_i` as unsigned values.
- R5: `ovf_o` is 1 exactly when the true signed result lies outside −2^(W−1) .. 2^(W−1)−1. For W = 8 that range is −128 .. +127, so 127+1, −128−1 and 0−(−128) all overflow.
- R6: With both mode lines high, `sum_o`, `carry_o` and `ovf_o` equal those of subtraction and `mode_err_o` is 1. In every other mode `mode_err_o` is 0.
- R7: The unit holds no state. All outputs follow a change of inputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | W | First signed operand (minuend / augend) |
| opb_i | input | W | Second signed operand (subtrahend / addend) |
| add_req_i | input | 1 | Request addition |
| sub_req_i | input | 1 | Request subtraction (also the adder carry-in) |
| sum_o | output | W | Result, carry beyond bit W−1 discarded |
| carry_o | output | 1 | Raw carry out of the top bit |
| ovf_o | output | 1 | Signed overflow |
| mode_err_o | output | 1 | Both mode lines high |

## Verification
On every input change, the assertions check the following:
- the result arithmetic in add and subtract modes;
- pass-through with quiet flags;
- the unsigned meaning of the carry during subtraction;
- overflow against the sign pattern of the operands and the result;
- the error flag against the mode lines.

Only the bench scenarios show the remaining behaviour. These are the exact range limits, where wrap-around must coincide with the flag, and the rule that the illegal mode reproduces subtraction bit for bit. They also cover the absence of any clock dependence, seen by changing inputs between edges.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef enum logic [1:0] {
    OPM_PASS = 2'b00,
    OPM_ADD  = 2'b01,
    OPM_SUB  = 2'b10,
    OPM_BOTH = 2'b11
  } op_mode_e;

  typedef struct packed {
    logic gate_b;
    logic invert_b;
    logic carry_in;
    logic illegal;
  } op_ctrl_t;

  function automatic op_ctrl_t decode_mode(input op_mode_e m);
    op_ctrl_t c;
    c = '0;
    unique case (m)
      OPM_PASS: c = '0;
      OPM_ADD: begin
        c.gate_b = 1'b1;
      end
      OPM_SUB: begin
        c.gate_b   = 1'b1;
        c.invert_b = 1'b1;
        c.carry_in = 1'b1;
      end
      OPM_BOTH: begin
        c.gate_b   = 1'b1;
        c.invert_b = 1'b1;
        c.carry_in = 1'b1;
        c.illegal  = 1'b1;
      end
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/addsub_mode_dec.sv
module addsub_mode_dec
  import addsub_pkg::*;
(
  input  logic     add_req_i,
  input  logic     sub_req_i,
  output op_ctrl_t ctrl_o
);

  op_mode_e mode;

  always_comb begin
    mode   = op_mode_e'({sub_req_i, add_req_i});
    ctrl_o = decode_mode(mode);
  end

endmodule

// File: rtl/addsub_operand_gate.sv
module addsub_operand_gate #(
  parameter int W = 8
) (
  input  logic [W-1:0] opb_i,
  input  logic         gate_i,
  input  logic         invert_i,
  output logic [W-1:0] beff_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic pass_true;
    logic pass_inv;
    assign pass_true  = gate_i & ~invert_i &  opb_i[i];
    assign pass_inv   = gate_i &  invert_i & ~opb_i[i];
    assign beff_o[i]  = pass_true | pass_inv;
  end

endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         c_sign_in_o,
  output logic         c_sign_out_o
);

  localparam int MSB = W - 1;

  logic [W:0] chain;

  assign chain[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_fa
    logic half;
    assign half         = a_i[i] ^ b_i[i];
    assign sum_o[i]     = half ^ chain[i];
    assign chain[i+1]   = (a_i[i] & b_i[i]) | (chain[i] & half);
  end

  assign c_sign_in_o  = chain[MSB];
  assign c_sign_out_o = chain[W];

endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
  import addsub_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic         add_req_i,
  input  logic         sub_req_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o,
  output logic         mode_err_o
);

  op_ctrl_t     ctrl;
  logic [W-1:0] b_eff;
  logic         c_into_sign;
  logic         c_out_sign;

  addsub_mode_dec u_dec (
    .add_req_i (add_req_i),
    .sub_req_i (sub_req_i),
    .ctrl_o    (ctrl)
  );

  addsub_operand_gate #(.W(W)) u_gate (
    .opb_i    (opb_i),
    .gate_i   (ctrl.gate_b),
    .invert_i (ctrl.invert_b),
    .beff_o   (b_eff)
  );

  addsub_ripple #(.W(W)) u_add (
    .a_i          (opa_i),
    .b_i          (b_eff),
    .cin_i        (ctrl.carry_in),
    .sum_o        (sum_o),
    .c_sign_in_o  (c_into_sign),
    .c_sign_out_o (c_out_sign)
  );

  assign carry_o    = c_out_sign;
  assign ovf_o      = c_into_sign ^ c_out_sign;
  assign mode_err_o = ctrl.illegal;

endmodule

// File: rtl/addsub_unit_chk.sv
module addsub_unit_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] opa_i,
  input logic [W-1:0] opb_i,
  input logic         add_req_i,
  input logic         sub_req_i,
  input logic [W-1:0] sum_o,
  input logic         carry_o,
  input logic         ovf_o,
  input logic         mode_err_o
);

  localparam int MSB = W - 1;

  logic [W-1:0] add_ref;
  logic [W-1:0] sub_ref;
  logic         add_sign_ovf;
  logic         sub_sign_ovf;

  always_comb begin
    add_ref      = opa_i + opb_i;
    sub_ref      = opa_i - opb_i;
    add_sign_ovf = (opa_i[MSB] == opb_i[MSB]) && (sum_o[MSB] != opa_i[MSB]);
    sub_sign_ovf = (opa_i[MSB] != opb_i[MSB]) && (sum_o[MSB] != opa_i[MSB]);
  end

  always_comb begin
    // R1
    add_result_chk: assert (!(add_req_i && !sub_req_i) || (sum_o == add_ref));
    // R2
    sub_result_chk: assert (!sub_req_i || (sum_o == sub_ref));
    // R3
    pass_thru_chk: assert ((add_req_i || sub_req_i) || (sum_o == opa_i && !carry_o && !ovf_o));
    // R4
    sub_carry_chk: assert (!sub_req_i || (carry_o == (opa_i >= opb_i)));
    // R5
    add_ovf_chk: assert (!(add_req_i && !sub_req_i) || (ovf_o == add_sign_ovf));
    // R5
    sub_ovf_chk: assert (!sub_req_i || (ovf_o == sub_sign_ovf));
    // R6
    mode_err_chk: assert (mode_err_o == (add_req_i && sub_req_i));
  end

endmodule

bind addsub_unit addsub_unit_chk #(.W(W)) chk_i (.*);

// File: tb/addsub_unit_test.sv
module addsub_unit_test;

  localparam int W    = 8;
  localparam int SMAX = (1 << (W - 1)) - 1;
  localparam int SMIN = -(1 << (W - 1));

  logic         clk;
  logic [W-1:0] opa;
  logic [W-1:0] opb;
  logic         add_req;
  logic         sub_req;
  logic [W-1:0] sum;
  logic         carry;
  logic         ovf;
  logic         merr;

  int checks;
  int fails;
  int cycles;

  addsub_unit #(.W(W)) uut (
    .opa_i      (opa),
    .opb_i      (opb),
    .add_req_i  (add_req),
    .sub_req_i  (sub_req),
    .sum_o      (sum),
    .carry_o    (carry),
    .ovf_o      (ovf),
    .mode_err_o (merr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [W+2:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic ad, input logic sb);
    logic [W:0]   full;
    logic [W-1:0] beff;
    int           sa;
    int           sbv;
    int           tru;
    logic         o;
    sa  = $signed(a);
    sbv = $signed(b);
    if (sb) begin
      beff = ~b;
      tru  = sa - sbv;
    end else if (ad) begin
      beff = b;
      tru  = sa + sbv;
    end else begin
      beff = '0;
      tru  = sa;
    end
    full = {1'b0, a} + {1'b0, beff} + {{W{1'b0}}, sb};
    o    = (tru > SMAX) || (tru < SMIN);
    return {(ad & sb), o, full[W], full[W-1:0]};
  endfunction

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic ad, input logic sb, input string tag);
    logic [W+2:0] e;
    @(negedge clk);
    opa = a; opb = b; add_req = ad; sub_req = sb;
    #1;
    e = model(a, b, ad, sb);
    checks++;
    if ({merr, ovf, carry, sum} !== e) begin
      fails++;
      $display("FAIL %s: a=%h b=%h add=%b sub=%b got err=%b ovf=%b c=%b sum=%h exp err=%b ovf=%b c=%b sum=%h",
               tag, a, b, ad, sb, merr, ovf, carry, sum, e[W+2], e[W+1], e[W], e[W-1:0]);
    end
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++;
        fails++;
        $display("FAIL watchdog: got cycles=%0d exp below 100000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    checks = 0;
    fails  = 0;
    opa = '0; opb = '0; add_req = 1'b0; sub_req = 1'b0;
    // R3 idle state: all zero inputs give all zero outputs
    apply(8'h00, 8'h00, 1'b0, 1'b0, "R3 idle");
    apply(8'h7F, 8'h55, 1'b0, 1'b0, "R3 pass max");
    apply(8'h80, 8'hFF, 1'b0, 1'b0, "R3 pass min");
    // R1 / R5 addition limits
    apply(8'h7F, 8'h01, 1'b1, 1'b0, "R5 add 127+1");
    apply(8'h80, 8'hFF, 1'b1, 1'b0, "R5 add -128-1");
    apply(8'h09, 8'hFC, 1'b1, 1'b0, "R1 add 9+(-4)");
    apply(8'h09, 8'hF7, 1'b1, 1'b0, "R4 add 9+(-9) carry");
    // R2 / R4 / R5 subtraction limits
    apply(8'h80, 8'h01, 1'b0, 1'b1, "R5 sub -128-1");
    apply(8'h00, 8'h80, 1'b0, 1'b1, "R5 sub 0-(-128)");
    apply(8'h7F, 8'hFF, 1'b0, 1'b1, "R5 sub 127-(-1)");
    apply(8'hFF, 8'hFF, 1'b0, 1'b1, "R4 sub equal");
    apply(8'h04, 8'h06, 1'b0, 1'b1, "R2 sub 4-6");
    apply(8'h05, 8'h00, 1'b0, 1'b1, "R4 sub minus zero");
    // R6 illegal mode
    apply(8'h00, 8'h80, 1'b1, 1'b1, "R6 both ovf");
    apply(8'h33, 8'h11, 1'b1, 1'b1, "R6 both");
    // R7 outputs follow inputs between clock edges
    @(posedge clk);
    #1;
    opa = 8'h10; opb = 8'h20; add_req = 1'b1; sub_req = 1'b0;
    #1;
    checks++;
    if (sum !== 8'h30 || merr !== 1'b0) begin
      fails++;
      $display("FAIL R7: got sum=%h err=%b exp sum=30 err=0", sum, merr);
    end
    sub_req = 1'b1; add_req = 1'b0;
    #1;
    checks++;
    if (sum !== 8'hF0 || carry !== 1'b0) begin
      fails++;
      $display("FAIL R7: got sum=%h c=%b exp sum=f0 c=0", sum, carry);
    end
    // constrained random over all modes
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] ra;
      logic [W-1:0] rb;
      logic [1:0]   rm;
      ra = W'($urandom);
      rb = W'($urandom);
      rm = 2'($urandom);
      if (i % 7 == 0) ra = (i % 2 == 0) ? 8'h7F : 8'h80;
      case (rm)
        2'b00:   apply(ra, rb, 1'b0, 1'b0, "R3 random");
        2'b01:   apply(ra, rb, 1'b1, 1'b0, "R1 random");
        2'b10:   apply(ra, rb, 1'b0, 1'b1, "R2 random");
        default: apply(ra, rb, 1'b1, 1'b1, "R6 random");
      endcase
    end
    finish_run();
  end

endmodule